// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block carries out the three register-to-register operations of a small 16-bit processor: addition, bitwise AND and bitwise complement. All of them work on two's-complement words. It takes an instruction word and decodes from it two source register selects and a destination register select. Bit 5 of the word picks the second operand: the second register value, or a 5-bit immediate that is sign-extended to the data width. The result, destination select and write strobe feed the register file directly and combinationally in the same cycle.

The block also holds the negative/zero/positive condition flags. On the clock edge after any register write, they are recomputed from the written value. The write may come from the operate datapath or from a separate load-result input, which the memory side uses for loads and address loads. The load input takes priority over a decoded operation. It writes to the destination select taken from the same instruction word. When a cycle has no register write, the flags hold their value.

Top module: `operate_unit`

## Requirements
- R1: `src_a_sel` always equals `instr[8:6]` and `src_b_sel` always equals `instr[2:0]`, in the same cycle.
- R2: With `instr_valid` high, `load_valid` low, opcode `instr[15:12]` = 4'b0001 and `instr[5]` = 0, the block drives `dst_we` = 1, `dst_sel` = `instr[11:9]` and `dst_data` = `src_a_data + src_b_data`, all combinationally.
- R3: When `instr[5]` = 1 for the add or AND opcodes, the second operand is `instr[4:0]` sign-extended to 16 bits, and `src_b_data` has no effect.
- R4: Opcode 4'b0101 writes `src_a_data & operand_b`, using the same mode selection as R2 and R3.
- R5: Opcode 4'b1001 writes `~src_a_data`. Bits `instr[5:0]` and `src_b_data` have no effect on the result.
- R6: When `load_valid` is high, the block drives `dst_we` = 1, `dst_sel` = `instr[11:9]` and `dst_data` = `load_data`. This holds regardless of `instr_valid` or the opcode.
- R7: When `load_valid` is low and either `instr_valid` is low or the opcode is not one of the three above, `dst_we` is 0 and the flags keep their value.
- R8: On the rising clock edge of a cycle with `dst_we` = 1, the flags become N = `dst_data[15]`, Z = (`dst_data` == 0) and P = neither.
- R9: While reset is active and after it is released, Z = 1 and N = P = 0. Exactly one flag is set in every cycle.
- R10: Addition wraps modulo 2^16. For example, 16'h7FFF + 1 gives 16'h8000, which sets N, and 16'hFFFF + 1 gives 0, which sets Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| src_a_data | input | 16 | Value read from register `src_a_sel` |
| src_b_data | input | 16 | Value read from register `src_b_sel` |
| load_valid | input | 1 | Load result is to be written this cycle |
| load_data | input | 16 | Load result value |
| src_a_sel | output | 3 | First read register select |
| src_b_sel | output | 3 | Second read register select |
| dst_sel | output | 3 | Write register select |
| dst_data | output | 16 | Write data |
| dst_we | output | 1 | Write enable |
| flag_neg | output | 1 | Last written value was negative |
| flag_zero | output | 1 | Last written value was zero |
| flag_pos | output | 1 | Last written value was strictly positive |

## Verification
The only state in the block is the flag register. If it is wrong, the three flag outputs show it on the edge after the faulty write. The fault also persists through every following cycle without a write, until the next write overwrites it. For that reason, the bench checks the flags on every cycle, including cycles that do not write. A broken one-hot encoding or a missed hold shows up at the ports within one clock. The datapath faults are combinational and visible in the same cycle. These include a wrong mode bit, an immediate that is not sign-extended and a load priority that is swapped.

// File: rtl/operate_unit.sv
module operate_unit #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [DATA_W-1:0] src_a_data,
  input  logic [DATA_W-1:0] src_b_data,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic [2:0]        src_a_sel,
  output logic [2:0]        src_b_sel,
  output logic [2:0]        dst_sel,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_we,
  output logic              flag_neg,
  output logic              flag_zero,
  output logic              flag_pos
);
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [3:0]        opc;
  logic [DATA_W-1:0] imm_ext, opnd_b, alu_res;
  logic              is_oper;
  logic [2:0]        flags_q;

  assign opc       = instr[15:12];
  assign src_a_sel = instr[8:6];
  assign src_b_sel = instr[2:0];
  assign dst_sel   = instr[11:9];

  assign imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign opnd_b  = instr[5] ? imm_ext : src_b_data;
  assign is_oper = instr_valid && (opc == OPC_ADD || opc == OPC_AND || opc == OPC_NOT);

  always_comb begin
    case (opc)
      OPC_ADD: alu_res = src_a_data + opnd_b;
      OPC_AND: alu_res = src_a_data & opnd_b;
      default: alu_res = ~src_a_data;
    endcase
  end

  assign dst_we   = load_valid | is_oper;
  assign dst_data = load_valid ? load_data : alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= 3'b010;
    else if (dst_we)
      flags_q <= {dst_data[DATA_W-1], dst_data == '0,
                  !dst_data[DATA_W-1] && dst_data != '0};
  end

  assign flag_neg  = flags_q[2];
  assign flag_zero = flags_q[1];
  assign flag_pos  = flags_q[0];

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_neg, flag_zero, flag_pos}) == 1);

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_we |=> $stable({flag_neg, flag_zero, flag_pos}));

  p_flags_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> (flag_zero == ($past(dst_data) == '0)));

  p_flags_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> (flag_neg == $past(dst_data[DATA_W-1])));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> (dst_we && dst_data == load_data));

  p_not_ignores_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !load_valid && instr[15:12] == 4'b1001) |-> (dst_data == ~src_a_data));

  p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !load_valid) |-> !dst_we);
endmodule

// File: tb/operate_unit_tb.sv
module operate_unit_tb;
  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, load_valid = 0;
  logic [15:0] instr = 0, src_a_data = 0, src_b_data = 0, load_data = 0;
  logic [2:0] src_a_sel, src_b_sel, dst_sel;
  logic [15:0] dst_data;
  logic dst_we, flag_neg, flag_zero, flag_pos;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  sa, sb, dsel;
    logic        we;
    logic [15:0] data;
    logic [2:0]  flags;
    string       req;
  } exp_t;
  exp_t q[$];
  logic [2:0] model_flags = 3'b010;

  always #4 clk = ~clk;

  operate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .src_a_data(src_a_data), .src_b_data(src_b_data),
    .load_valid(load_valid), .load_data(load_data),
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .dst_sel(dst_sel),
    .dst_data(dst_data), .dst_we(dst_we),
    .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_pos(flag_pos)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [15:0] ins, input logic [15:0] a,
                       input logic [15:0] b, input logic lv, input logic [15:0] ld,
                       input string req);
    exp_t e;
    logic [15:0] opb, res;
    @(negedge clk);
    instr_valid = iv; instr = ins; src_a_data = a; src_b_data = b;
    load_valid = lv; load_data = ld;
    opb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
    e.sa = ins[8:6]; e.sb = ins[2:0]; e.dsel = ins[11:9]; e.req = req;
    e.we = 1'b0; res = 16'h0;
    if (lv) begin e.we = 1'b1; res = ld; end
    else if (iv && ins[15:12] == 4'b0001) begin e.we = 1'b1; res = a + opb; end
    else if (iv && ins[15:12] == 4'b0101) begin e.we = 1'b1; res = a & opb; end
    else if (iv && ins[15:12] == 4'b1001) begin e.we = 1'b1; res = ~a; end
    e.data = res;
    if (e.we) model_flags = res[15] ? 3'b100 : (res == 0 ? 3'b010 : 3'b001);
    e.flags = model_flags;
    q.push_back(e);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] d,
                                     input logic [2:0] s1, input logic [5:0] low);
    return {op, d, s1, low};
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(src_a_sel == e.sa, "R1", "src_a_sel", {13'b0, src_a_sel}, {13'b0, e.sa});
        check(src_b_sel == e.sb, "R1", "src_b_sel", {13'b0, src_b_sel}, {13'b0, e.sb});
        check(dst_we == e.we, e.req, "dst_we", {15'b0, dst_we}, {15'b0, e.we});
        if (e.we) begin
          check(dst_sel == e.dsel, e.req, "dst_sel", {13'b0, dst_sel}, {13'b0, e.dsel});
          check(dst_data == e.data, e.req, "dst_data", dst_data, e.data);
        end
        check({flag_neg, flag_zero, flag_pos} == e.flags, {e.req, "/R8"}, "flags",
              {13'b0, flag_neg, flag_zero, flag_pos}, {13'b0, e.flags});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2;
    check({flag_neg, flag_zero, flag_pos} == 3'b010, "R9", "reset flags",
          {13'b0, flag_neg, flag_zero, flag_pos}, 16'h2);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check({flag_neg, flag_zero, flag_pos} == 3'b010, "R9", "post-reset flags",
          {13'b0, flag_neg, flag_zero, flag_pos}, 16'h2);
    check(dst_we == 1'b0, "R7", "idle dst_we", {15'b0, dst_we}, 16'h0);

    drive(1, mk(4'b0001, 3'd3, 3'd1, 6'b000_010), 16'd5, 16'd7, 0, 16'h0, "R2");
    drive(1, mk(4'b0001, 3'd6, 3'd5, 6'b000_111), 16'h0100, 16'hF000, 0, 16'h0, "R2");
    drive(1, mk(4'b0001, 3'd2, 3'd2, 6'b111_111), 16'h0000, 16'h1234, 0, 16'h0, "R3");
    drive(1, mk(4'b0001, 3'd0, 3'd4, 6'b101_111), 16'h0001, 16'h8000, 0, 16'h0, "R3");
    drive(1, mk(4'b0001, 3'd1, 3'd1, 6'b100_001), 16'h7FFF, 16'h0, 0, 16'h0, "R10");
    drive(1, mk(4'b0001, 3'd1, 3'd1, 6'b100_001), 16'hFFFF, 16'h5555, 0, 16'h0, "R10");
    drive(1, mk(4'b0101, 3'd7, 3'd3, 6'b000_110), 16'hF0F0, 16'h3C3C, 0, 16'h0, "R4");
    drive(1, mk(4'b0101, 3'd4, 3'd0, 6'b110_000), 16'h1234, 16'hFFFF, 0, 16'h0, "R4");
    drive(1, mk(4'b0101, 3'd4, 3'd0, 6'b101_111), 16'h8765, 16'h0000, 0, 16'h0, "R4");
    drive(1, mk(4'b1001, 3'd5, 3'd2, 6'b111_111), 16'h00FF, 16'h0000, 0, 16'h0, "R5");
    drive(1, mk(4'b1001, 3'd5, 3'd2, 6'b010_101), 16'hFFFF, 16'hABCD, 0, 16'h0, "R5");
    drive(1, mk(4'b1001, 3'd3, 3'd6, 6'b000_000), 16'h8000, 16'h1111, 0, 16'h0, "R5");
    drive(0, mk(4'b0001, 3'd3, 3'd1, 6'b000_010), 16'd1, 16'd1, 0, 16'h0, "R7");
    drive(1, mk(4'b0000, 3'd7, 3'd7, 6'b111_111), 16'h8000, 16'h8000, 0, 16'h0, "R7");
    drive(1, mk(4'b1100, 3'd2, 3'd1, 6'b000_000), 16'h0000, 16'h0000, 0, 16'h0, "R7");
    drive(0, mk(4'b0010, 3'd6, 3'd0, 6'b000_000), 16'h0, 16'h0, 1, 16'h0000, "R6");
    drive(0, mk(4'b0110, 3'd2, 3'd0, 6'b000_000), 16'h0, 16'h0, 1, 16'h9000, "R6");
    drive(1, mk(4'b0001, 3'd1, 3'd2, 6'b000_011), 16'd1, 16'd1, 1, 16'h0042, "R6");
    drive(0, 16'h0, 16'h0, 16'h0, 0, 16'h0, "R7");
    repeat (4) @(posedge clk);
    #2;
    check(q.size() == 0, "R2", "queue drained", q.size(), 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule